// File: doc/BRIEF.md
# Prescaled Timer and Event Counter

This block is a single timer/event counter whose count lives in two cascaded byte registers. A free-running divider splits the core clock into peripheral cycles of six clocks and produces a one-clock tick. All counting, sampling and gate decisions happen only on that tick. In timer mode the count advances once per tick. In event mode, an external input is sampled on each tick. The count advances when the previous sample was high and the current sample is low.

A 4-bit configuration field selects three things: optional gating by an external enable input, the count source, and one of four count shapes. The shapes are a 13-bit count with a 5-bit prescaler, a full 16-bit count, an 8-bit count with automatic reload, and a halted state. A run bit starts and stops counting. When the count wraps, an overflow flag is set, and the flag drives the interrupt request. Software reaches the configuration, the run bit, the flag and both count bytes through a small byte-wide register port.

Top module: `timer_counter`

## Requirements
- R1: After reset, the control register, both count bytes and irq_o all read 0, and no counting takes place.
- R2: When the source select is 0, the count advances by exactly one on every sixth clock edge while counting is enabled. Any 6·k consecutive edges therefore add exactly k.
- R3: While the run bit is 0 the count bytes hold their value, even if timer ticks or input edges occur. Setting the run bit does not clear the count.
- R4: With mode pair 01, the high byte and the low byte form one 16-bit count. Wrapping from 0xFFFF to 0x0000 sets the overflow flag.
- R5: With mode pair 00, low-byte bits [4:0] act as a prescaler into the high byte, forming a 13-bit count. Low-byte bits [7:5] are left unchanged. When the count wraps from the top value to 0, the flag is set.
- R6: With mode pair 10, only the low byte counts. When it wraps past 0xFF, it is loaded with the high byte, the high byte is unchanged, and the flag is set.
- R7: With mode pair 11, the count bytes never change except through software writes.
- R8: When the source select is 1, the count advances once for each high-to-low change between two successive per-tick samples of ev_i. It advances at no other time.
- R9: When the gate-enable bit is 1, counting happens only on ticks where gate_i is high.
- R10: irq_o equals the overflow flag. A write to the control register loads the flag from bit 5. A one-clock irq_ack_i clears it. If an overflow occurs in the same clock as an acknowledge, the flag stays set.
- R11: The register map is as follows. Address 0 is control: bits [3:0] hold the configuration, bit 3 is gate enable, bit 2 is source select, and bits [1:0] are the mode pair. Bit 4 is run, bit 5 is the flag, and bits [7:6] read 0. Address 1 is the low count byte and address 2 is the high count byte; both are writable and readable. Address 3 reads 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ev_i | input | 1 | External event input |
| gate_i | input | 1 | External count-enable input |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request (overflow flag) |

## Verification
The hardest case to reach is an overflow that lands in the same clock as an acknowledge pulse. The reason is that the divider phase cannot be seen from the ports. To reach it, the stimulus presets the count two below the wrap point and starts the counter. It then polls the low byte each clock until the first increment shows. That reveals the tick phase, so the bench can raise irq_ack_i for exactly the clock of the next tick, which is the one that overflows. All other counting checks measure differences over whole multiples of six clocks, so they do not depend on the phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRE13   = 2'b00,
    MODE_FULL16  = 2'b01,
    MODE_RELOAD8 = 2'b10,
    MODE_HALT    = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      ext_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int CFG_W = $bits(tmr_cfg_t);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam int RUN_BIT  = CFG_W;
  localparam int FLAG_BIT = CFG_W + 1;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/tmr_evt_sample.sv
module tmr_evt_sample (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ev_i,
  output logic fall_o
);
  logic samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b0;
    else if (tick_i) samp_q <= ev_i;
  end

  // previous sample high, current sample low
  assign fall_o = tick_i & samp_q & ~ev_i;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  tmr_mode_e         mode_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o
);
  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              ovf;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    ovf  = 1'b0;
    if (inc_i) begin
      unique case (mode_i)
        MODE_PRE13: begin
          if (&lo_q[PRE_W-1:0]) begin
            lo_d[PRE_W-1:0] = '0;
            hi_d            = hi_q + 1'b1;
            ovf             = &hi_q;
          end else begin
            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
        MODE_FULL16: begin
          {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
          ovf          = &{hi_q, lo_q};
        end
        MODE_RELOAD8: begin
          if (&lo_q) begin
            lo_d = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign ovf_o = ovf;
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import tmr_pkg::*;
#(
  parameter int DIV    = 6,
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              ev_i,
  input  logic              gate_i,
  input  logic              irq_ack_i,
  output logic              irq_o
);
  tmr_cfg_t          cfg_q;
  tmr_mode_e         mode_w;
  logic              run_q, flag_q, flag_d;
  logic              tick, fall, inc, ovf, gate_ok;
  logic              wr_ctrl, wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo, hi;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_lo   = wr_en_i && (addr_i == ADDR_LO);
  assign wr_hi   = wr_en_i && (addr_i == ADDR_HI);
  assign mode_w  = cfg_q.mode;

  tmr_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  tmr_evt_sample u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .ev_i  (ev_i),
    .fall_o(fall)
  );

  assign gate_ok = ~cfg_q.gate_en | gate_i;
  assign inc     = run_q & gate_ok & (cfg_q.ext_sel ? fall : tick);

  tmr_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc),
    .mode_i (mode_w),
    .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi),
    .wdata_i(wdata_i),
    .lo_o   (lo),
    .hi_o   (hi),
    .ovf_o  (ovf)
  );

  // overflow beats acknowledge beats software write
  always_comb begin
    flag_d = flag_q;
    if (wr_ctrl)   flag_d = wdata_i[FLAG_BIT];
    if (irq_ack_i) flag_d = 1'b0;
    if (ovf)       flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg_q <= tmr_cfg_t'(wdata_i[CFG_W-1:0]);
        run_q <= wdata_i[RUN_BIT];
      end
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CFG_W-1:0] = cfg_q;
        rdata_o[RUN_BIT]   = run_q;
        rdata_o[FLAG_BIT]  = flag_q;
      end
      ADDR_LO: rdata_o = lo;
      ADDR_HI: rdata_o = hi;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              inc,
  input logic              ovf,
  input logic [1:0]        mode,
  input logic [BYTE_W-1:0] lo,
  input logic [BYTE_W-1:0] hi,
  input logic              flag,
  input logic              run,
  input logic              wr_en,
  input logic              wr_ctrl,
  input logic              ack
);
  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !wr_en) |=> $stable({hi, lo}));

  assert_hold_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_en) |=> $stable({hi, lo}));

  assert_ovf_sets_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> flag);

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b10 && inc && (&lo) && !wr_en) |=> (lo == $past(hi) && flag));

  assert_halt_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'b11 && !wr_en) |=> $stable({hi, lo}));

  assert_ack_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !ovf && !wr_ctrl) |=> !flag);
endmodule

bind timer_counter tmr_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .inc    (inc),
  .ovf    (ovf),
  .mode   (mode_w),
  .lo     (lo),
  .hi     (hi),
  .flag   (flag_q),
  .run    (run_q),
  .wr_en  (wr_en_i),
  .wr_ctrl(wr_ctrl),
  .ack    (irq_ack_i)
);

// File: tb/tb_timer_counter.sv
module tb_timer_counter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ev = 1'b0;
  logic       gate = 1'b0;
  logic       ack = 1'b0;
  logic       irq;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timer_counter dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .ev_i     (ev),
    .gate_i   (gate),
    .irq_ack_i(ack),
    .irq_o    (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected count after k increments, from the requirements' arithmetic
  task automatic model(input int m, input int k, inout logic [7:0] lo,
                       inout logic [7:0] hi, inout logic f);
    int v;
    case (m)
      0: begin
        v = hi * 32 + lo[4:0] + k;
        if (v >= 8192) f = 1'b1;
        v = v % 8192;
        lo = {lo[7:5], v[4:0]};
        hi = v[12:5];
      end
      1: begin
        v = {hi, lo} + k;
        if (v >= 65536) f = 1'b1;
        lo = v[7:0];
        hi = v[15:8];
      end
      2: begin
        for (int i = 0; i < k; i++) begin
          if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
          else lo = lo + 8'd1;
        end
      end
      default: ;
    endcase
  endtask

  task automatic run_case(input int m, input logic [7:0] lo0, input logic [7:0] hi0,
                          input int k);
    logic [7:0] elo, ehi, glo, ghi, gc;
    logic ef;
    string req;
    wr(2'd0, 8'h00);
    wr(2'd1, lo0);
    wr(2'd2, hi0);
    wr(2'd0, 8'h10 | 8'(m));
    waitn(6 * k);
    rd(2'd1, glo);
    rd(2'd2, ghi);
    rd(2'd0, gc);
    elo = lo0; ehi = hi0; ef = 1'b0;
    model(m, k, elo, ehi, ef);
    case (m)
      0: req = "R5";
      1: req = "R4";
      2: req = "R6";
      default: req = "R7";
    endcase
    check({req, " low byte"}, glo, elo);
    check({req, " high byte"}, ghi, ehi);
    check({req, " flag"}, gc[5], ef);
    check("R10 irq equals flag", irq, gc[5]);
    wr(2'd0, 8'h00);
  endtask

  logic [7:0] lo_set [6] = '{8'h00, 8'h1E, 8'h1F, 8'hFE, 8'hFF, 8'hE7};
  logic [7:0] hi_set [3] = '{8'h00, 8'h7F, 8'hFF};

  initial begin
    logic [7:0] v0, v1, c;
    waitn(3);
    rst_ni = 1'b1;
    waitn(1);

    // R1 reset state
    rd(2'd0, c);  check("R1 ctrl", c, 0);
    rd(2'd1, v0); check("R1 low", v0, 0);
    rd(2'd2, v0); check("R1 high", v0, 0);
    check("R1 irq", irq, 0);
    waitn(18);
    rd(2'd1, v0); check("R1 idle low", v0, 0);

    // R11 register map
    wr(2'd0, 8'hCB);
    rd(2'd0, c); check("R11 ctrl upper bits read 0", c, 8'h0B);
    rd(2'd3, c); check("R11 addr3 reads 0", c, 0);
    wr(2'd1, 8'h5A); wr(2'd2, 8'hA5);
    rd(2'd1, c); check("R11 low rw", c, 8'h5A);
    rd(2'd2, c); check("R11 high rw", c, 8'hA5);
    wr(2'd0, 8'h00);

    // R2 timer rate, R3 preset retained on run
    wr(2'd1, 8'h34); wr(2'd2, 8'h12);
    wr(2'd0, 8'h11);
    rd(2'd1, v0); check("R3 run keeps count", v0, 8'h34);
    for (int k = 1; k <= 5; k++) begin
      rd(2'd1, v0);
      waitn(6 * k);
      rd(2'd1, v1);
      check("R2 increments per 6k clocks", 8'(v1 - v0), k);
    end
    wr(2'd0, 8'h01);
    rd(2'd1, v0);
    waitn(36);
    rd(2'd1, v1);
    check("R3 stopped holds", v1, v0);

    // sweep over modes, presets and lengths: R4 R5 R6 R7
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 3; b++)
          for (int k = 1; k <= 4; k++)
            run_case(m, lo_set[a], hi_set[b], k);

    // R8 event counting, and R3 events ignored while stopped
    ev = 1'b0;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    waitn(12);
    for (int i = 0; i < 3; i++) begin ev = 1'b1; waitn(12); ev = 1'b0; waitn(12); end
    rd(2'd1, c); check("R3 events ignored when stopped", c, 0);
    wr(2'd0, 8'h15);
    for (int n = 1; n <= 4; n++) begin
      for (int i = 0; i < n; i++) begin ev = 1'b1; waitn(12); ev = 1'b0; waitn(12); end
      rd(2'd1, c); check("R8 falling edges counted", c, n * (n + 1) / 2);
    end
    ev = 1'b1; waitn(30);
    rd(2'd1, c); check("R8 steady high not counted", c, 10);
    ev = 1'b0; waitn(12);
    rd(2'd1, c); check("R8 single fall", c, 11);
    wr(2'd0, 8'h00);

    // R9 gate
    gate = 1'b0;
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd0, 8'h19);
    waitn(30);
    rd(2'd1, c); check("R9 gate low blocks", c, 0);
    gate = 1'b1;
    rd(2'd1, v0);
    waitn(18);
    rd(2'd1, v1); check("R9 gate high counts", 8'(v1 - v0), 3);
    gate = 1'b0;
    wr(2'd0, 8'h00);

    // R10 overflow coincident with acknowledge
    wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
    wr(2'd0, 8'h11);
    for (int i = 0; i < 12; i++) begin
      rd(2'd1, v0);
      if (v0 == 8'hFF) break;
      @(negedge clk);
    end
    check("R10 phase found", v0, 8'hFF);
    repeat (5) @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    rd(2'd1, v0); check("R10 wrapped low", v0, 0);
    rd(2'd0, c);  check("R10 ovf beats ack", c[5], 1);
    check("R10 irq raised", irq, 1);
    wr(2'd0, 8'h21);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    rd(2'd0, c); check("R10 ack clears", c[5], 0);
    check("R10 irq cleared", irq, 0);
    wr(2'd0, 8'h20);
    check("R10 software set", irq, 1);
    wr(2'd0, 8'h00);
    check("R10 software clear", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule